// File: doc/BRIEF.md
# Wavetable Voice Address and Loop Generator

This block walks one wavetable voice through sample memory. It keeps a play position that is unsigned fixed point, with 16 integer bits and 12 fractional bits. After a key-on it offers a pair of byte addresses on an address stream: the sample under the current position and the sample one whole step past it. It also offers the fraction and the play direction. Each accepted address pair moves the position by a pitch step, forward or backward. The loop mode then decides what happens at the loop bounds: stop, wrap, jump, or turn around.

The two fetched values come back on a sample stream. The block mixes them linearly using the fraction of the position that was issued. It applies the bit-inversion controls and offers the result on an output stream. Two single-cycle pulses go to neighbouring logic. One tells an envelope that forward play has first reached the loop start. The other asks a voice allocator to stop the voice.

All three streams use valid/ready, and a transfer happens on a cycle where both are high. The block runs one sample at a time: an address transfer, then a sample transfer, then an output transfer. While a valid is high and its ready is low, the block holds that stream's payload and its own state unchanged. Each consumer may hold back for any number of cycles. The control inputs are plain levels. The start address and the sample width are captured at key-on. The loop bounds, mode, step and link enable are read when the address transfer happens. The inversion controls are read when the sample transfer happens.

Top module: `wt_voice_addr`

## Requirements
- R1: A one-cycle `key_on` captures `start_addr` and `pcm8`, clears the position to 0.0 and the direction to forward (`dir_back`=0), and re-arms the loop-start pulse. On the next cycle `addr_valid` is high with `rd_addr_cur` equal to `start_addr` and `pos_frac` equal to 0. Key-on takes priority over every other event. After reset no stream is valid.
- R2: While `addr_valid` is high, `rd_addr_nxt` addresses the sample at integer index plus one: `rd_addr_cur`+1 in 8-bit mode, `rd_addr_cur`+2 in 16-bit mode, modulo 2^19.
- R3: For integer index i and start S, the byte address is (S+i) mod 2^19 when `pcm8`=1. When `pcm8`=0 it is (S+2i) mod 2^19 with bit 0 cleared.
- R4: With `loop_mode`=0 (one-shot), a step whose new position has integer part at or beyond both `loop_start` and `loop_end` pulses `voice_stop` for one cycle. The voice then finishes the sample already issued and goes idle.
- R5: With `loop_mode`=1 (forward loop), a step whose new position reaches `loop_end` or beyond has (`loop_end`−`loop_start`) whole samples subtracted from it. The fractional part is kept.
- R6: With `loop_mode`=2 (reverse loop), forward play that reaches `loop_start` continues backward from `loop_end` minus the overshoot. In backward play, going below `loop_start` restarts at `loop_end` minus the undershoot.
- R7: With `loop_mode`=3 (ping-pong), reaching `loop_end` going forward reflects the position about `loop_end` and turns backward. Going below `loop_start` backward reflects it about `loop_start` and turns forward.
- R8: The first forward step after key-on whose new position reaches `loop_start` pulses `ls_reached` for one cycle, but only when `ls_link`=1. The pulse comes at most once per key-on.
- R9: The output sample is p + floor((n−p)·f/4096), where p and n are the previous and next samples and f is the fraction of the issued position. In 16-bit mode p and n are the full signed `smp_prev`/`smp_next`. In 8-bit mode they are bits [7:0] of those inputs, sign-extended and multiplied by 256.
- R10: `sb_ctl` bit 0 XORs the mixed sample with 0x7FFF. Bit 1 XORs it with 0x8000.
- R11: The order is address transfer, then sample transfer, then output transfer, then back to an address offer. The position moves only on an address transfer. A stalled stream holds its payload.
- R12: After a stop, `addr_valid` stays low until the next `key_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_on | input | 1 | Start (or restart) the voice |
| start_addr | input | 19 | Byte address of sample 0, captured at key-on |
| pcm8 | input | 1 | 1 = 8-bit samples, 0 = 16-bit, captured at key-on |
| loop_start | input | 16 | Loop start, in whole samples |
| loop_end | input | 16 | Loop end, in whole samples |
| loop_mode | input | 2 | 0 one-shot, 1 forward, 2 reverse, 3 ping-pong |
| pitch_step | input | 20 | Position increment, 8.12 fixed point |
| ls_link | input | 1 | Enable the loop-start pulse |
| sb_ctl | input | 2 | Bit-inversion controls for the mixed sample |
| addr_valid | output | 1 | Address pair offered |
| addr_ready | input | 1 | Address pair accepted |
| rd_addr_cur | output | 19 | Byte address of the current sample |
| rd_addr_nxt | output | 19 | Byte address of the following sample |
| pos_frac | output | 12 | Fractional part of the position |
| dir_back | output | 1 | 1 while playing backward |
| smp_valid | input | 1 | Fetched sample pair present |
| smp_ready | output | 1 | Sample pair can be taken |
| smp_prev | input | 16 | Value fetched at `rd_addr_cur` |
| smp_next | input | 16 | Value fetched at `rd_addr_nxt` |
| out_valid | output | 1 | Mixed sample offered |
| out_ready | input | 1 | Mixed sample accepted |
| out_sample | output | 16 | Mixed, inverted sample |
| ls_reached | output | 1 | One-cycle loop-start pulse |
| voice_stop | output | 1 | One-cycle stop request |

## Verification
A wrong position or direction shows up on `rd_addr_cur`, `pos_frac` or `dir_back` on the first cycle of the next address offer. The address pair stays on the ports until it is taken, so a stall cannot hide the error. A wrong loop turn also shows up later: the next address is wrong, and any fraction error spreads into `out_sample` one transfer later. A lost or misplaced handshake step shows up at once as a valid or ready on the wrong cycle. A wrong stop or loop-start decision shows up as a missing or extra pulse on the cycle right after the address transfer that caused it.

// File: rtl/wt_voice_pkg.sv
package wt_voice_pkg;

  typedef enum logic [1:0] {
    LM_ONESHOT  = 2'd0,
    LM_FORWARD  = 2'd1,
    LM_REVERSE  = 2'd2,
    LM_PINGPONG = 2'd3
  } loop_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_SAMP = 2'd2,
    PH_OUT  = 2'd3
  } voice_phase_e;

endpackage

// File: rtl/wt_pos_step.sv
module wt_pos_step
  import wt_voice_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 12,
  parameter int STEP_W = 20
) (
  input  logic [IDX_W+FRAC_W-1:0] pos,
  input  logic                    dir,
  input  logic [STEP_W-1:0]       step,
  input  logic [IDX_W-1:0]        lp_start,
  input  logic [IDX_W-1:0]        lp_end,
  input  logic [1:0]              mode,
  input  logic                    link,
  input  logic                    seen,
  output logic [IDX_W+FRAC_W-1:0] pos_n,
  output logic                    dir_n,
  output logic                    ls_hit,
  output logic                    stop
);
  localparam int PW = IDX_W + FRAC_W;
  localparam int EW = PW + 2;

  logic signed [EW-1:0] cur_s, stp_s, adv, lsb, leb, res;

  always_comb begin
    cur_s  = {2'b00, pos};
    stp_s  = EW'(step);
    lsb    = {2'b00, lp_start, {FRAC_W{1'b0}}};
    leb    = {2'b00, lp_end, {FRAC_W{1'b0}}};
    adv    = dir ? (cur_s - stp_s) : (cur_s + stp_s);
    res    = adv;
    dir_n  = dir;
    stop   = 1'b0;
    ls_hit = !dir && (adv >= lsb) && link && !seen;
    case (loop_mode_e'(mode))
      LM_ONESHOT: begin
        stop = (adv >= lsb) && (adv >= leb);
      end
      LM_FORWARD: begin
        if (adv >= leb) res = adv - (leb - lsb);
      end
      LM_REVERSE: begin
        if (!dir && adv >= lsb) begin
          res   = leb - (adv - lsb);
          dir_n = 1'b1;
        end else if (dir && adv < lsb) begin
          res   = leb - (lsb - adv);
        end
      end
      default: begin
        if (!dir && adv >= leb) begin
          res   = leb - (adv - leb);
          dir_n = 1'b1;
        end else if (dir && adv < lsb) begin
          res   = lsb + (lsb - adv);
          dir_n = 1'b0;
        end
      end
    endcase
    pos_n = res[PW-1:0];
  end
endmodule

// File: rtl/wt_addr_map.sv
module wt_addr_map #(
  parameter int IDX_W   = 16,
  parameter int MADDR_W = 19
) (
  input  logic [MADDR_W-1:0] base,
  input  logic [IDX_W:0]     idx,
  input  logic               pcm8,
  output logic [MADDR_W-1:0] addr
);
  logic [MADDR_W-1:0] off;

  always_comb begin
    off = MADDR_W'(idx);
    if (pcm8) addr = base + off;
    else      addr = (base + (off << 1)) & ~MADDR_W'(1);
  end
endmodule

// File: rtl/wt_interp.sv
module wt_interp #(
  parameter int SMP_W  = 16,
  parameter int FRAC_W = 12
) (
  input  logic [SMP_W-1:0]  prev,
  input  logic [SMP_W-1:0]  next,
  input  logic [FRAC_W-1:0] frac,
  input  logic              pcm8,
  input  logic [1:0]        sb,
  output logic [SMP_W-1:0]  y
);
  localparam int HW = SMP_W / 2;
  localparam int DW = SMP_W + 1;
  localparam int MW = DW + FRAC_W + 1;

  logic [SMP_W-1:0]    pw, nw;
  logic signed [DW-1:0] pe, ne, dif;
  logic signed [MW-1:0] difx, frx, prod;
  logic signed [DW:0]   sum;

  always_comb begin
    pw   = pcm8 ? {prev[HW-1:0], {HW{1'b0}}} : prev;
    nw   = pcm8 ? {next[HW-1:0], {HW{1'b0}}} : next;
    pe   = {pw[SMP_W-1], pw};
    ne   = {nw[SMP_W-1], nw};
    dif  = ne - pe;
    difx = MW'(dif);
    frx  = MW'({1'b0, frac});
    prod = difx * frx;
    sum  = {pe[DW-1], pe} + prod[MW-1 -: DW+1];
    y    = sum[SMP_W-1:0] ^ {sb[1], {(SMP_W-1){sb[0]}}};
  end
endmodule

// File: rtl/wt_voice_addr.sv
module wt_voice_addr
  import wt_voice_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int FRAC_W  = 12,
  parameter int STEP_W  = 20,
  parameter int MADDR_W = 19,
  parameter int SMP_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_on,
  input  logic [MADDR_W-1:0] start_addr,
  input  logic               pcm8,
  input  logic [IDX_W-1:0]   loop_start,
  input  logic [IDX_W-1:0]   loop_end,
  input  logic [1:0]         loop_mode,
  input  logic [STEP_W-1:0]  pitch_step,
  input  logic               ls_link,
  input  logic [1:0]         sb_ctl,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [MADDR_W-1:0] rd_addr_cur,
  output logic [MADDR_W-1:0] rd_addr_nxt,
  output logic [FRAC_W-1:0]  pos_frac,
  output logic               dir_back,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [SMP_W-1:0]   smp_prev,
  input  logic [SMP_W-1:0]   smp_next,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SMP_W-1:0]   out_sample,
  output logic               ls_reached,
  output logic               voice_stop
);
  localparam int PW = IDX_W + FRAC_W;

  voice_phase_e       phase;
  logic [PW-1:0]      pos, pos_n;
  logic               dir, dir_n, ls_hit, stop_hit, seen, stopping, pcm8_q;
  logic [MADDR_W-1:0] start_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [SMP_W-1:0]   mix, out_q;
  logic [MADDR_W-1:0] map_addr [2];

  wt_pos_step #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) i_step (
    .pos(pos), .dir(dir), .step(pitch_step), .lp_start(loop_start),
    .lp_end(loop_end), .mode(loop_mode), .link(ls_link), .seen(seen),
    .pos_n(pos_n), .dir_n(dir_n), .ls_hit(ls_hit), .stop(stop_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_map
    wt_addr_map #(.IDX_W(IDX_W), .MADDR_W(MADDR_W)) i_map (
      .base(start_q),
      .idx((IDX_W+1)'(pos[PW-1:FRAC_W]) + (IDX_W+1)'(g)),
      .pcm8(pcm8_q),
      .addr(map_addr[g])
    );
  end

  wt_interp #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) i_interp (
    .prev(smp_prev), .next(smp_next), .frac(frac_q), .pcm8(pcm8_q),
    .sb(sb_ctl), .y(mix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      pos        <= '0;
      dir        <= 1'b0;
      seen       <= 1'b0;
      stopping   <= 1'b0;
      pcm8_q     <= 1'b0;
      start_q    <= '0;
      frac_q     <= '0;
      out_q      <= '0;
      ls_reached <= 1'b0;
      voice_stop <= 1'b0;
    end else begin
      ls_reached <= 1'b0;
      voice_stop <= 1'b0;
      if (key_on) begin
        pos      <= '0;
        dir      <= 1'b0;
        seen     <= 1'b0;
        stopping <= 1'b0;
        start_q  <= start_addr;
        pcm8_q   <= pcm8;
        phase    <= PH_ADDR;
      end else begin
        case (phase)
          PH_ADDR: if (addr_ready) begin
            pos        <= pos_n;
            dir        <= dir_n;
            frac_q     <= pos[FRAC_W-1:0];
            ls_reached <= ls_hit;
            seen       <= seen | ls_hit;
            voice_stop <= stop_hit;
            stopping   <= stop_hit;
            phase      <= PH_SAMP;
          end
          PH_SAMP: if (smp_valid) begin
            out_q <= mix;
            phase <= PH_OUT;
          end
          PH_OUT: if (out_ready) phase <= stopping ? PH_IDLE : PH_ADDR;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign addr_valid  = (phase == PH_ADDR);
  assign smp_ready   = (phase == PH_SAMP);
  assign out_valid   = (phase == PH_OUT);
  assign rd_addr_cur = map_addr[0];
  assign rd_addr_nxt = map_addr[1];
  assign pos_frac    = pos[FRAC_W-1:0];
  assign dir_back    = dir;
  assign out_sample  = out_q;

  // R2: the two mapped addresses sit one sample apart
  a_r2_next_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> rd_addr_nxt == MADDR_W'(rd_addr_cur + (pcm8_q ? MADDR_W'(1) : MADDR_W'(2))));

  // R3: 16-bit addresses are even
  a_r3_even_word: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !pcm8_q) |-> rd_addr_cur[0] == 1'b0);

  // R4: stop requests only come from one-shot play
  a_r4_stop_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    voice_stop |-> $past(loop_mode) == 2'd0);

  // R9: with no inversion, a 16-bit mix lies between its two inputs
  a_r9_mix_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !pcm8_q && sb_ctl == 2'd0) |->
      (($signed(mix) >= $signed(smp_prev) && $signed(mix) <= $signed(smp_next)) ||
       ($signed(mix) <= $signed(smp_prev) && $signed(mix) >= $signed(smp_next))));

  // R11: a stalled address offer holds
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !key_on) |=> (addr_valid && $stable(rd_addr_cur) && $stable(pos_frac)));

  // R11: a stalled output offer holds
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !key_on) |=> (out_valid && $stable(out_sample)));

endmodule

// File: tb/test_wt_voice_addr.sv
module test_wt_voice_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_on = 1'b0;
  logic [18:0] start_addr = '0;
  logic        pcm8 = 1'b0;
  logic [15:0] loop_start = '0, loop_end = '0;
  logic [1:0]  loop_mode = '0, sb_ctl = '0;
  logic [19:0] pitch_step = '0;
  logic        ls_link = 1'b0;
  logic        addr_valid, addr_ready = 1'b0;
  logic [18:0] rd_addr_cur, rd_addr_nxt;
  logic [11:0] pos_frac;
  logic        dir_back;
  logic        smp_valid = 1'b0, smp_ready;
  logic [15:0] smp_prev = '0, smp_next = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_sample;
  logic        ls_reached, voice_stop;

  always #10 clk = ~clk;

  wt_voice_addr i_wt_voice_addr (.*);

  int n_checks = 0, n_fail = 0, cyc = 0;
  // reference model state
  int     m_phase = 0;
  longint m_pos = 0;
  bit     m_dir = 0, m_seen = 0, m_stopping = 0, m_pcm = 0, m_done = 0;
  bit     m_ls = 0, m_stop = 0, m_first = 0;
  int     m_start = 0, m_frac = 0, m_out = 0, m_outs = 0;
  int     m_iss_cur = 0, m_iss_nxt = 0;
  bit     kon_req = 0, stall = 0;
  string  scen_tag = "R5";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int mapaddr(int s, longint idx, bit p8);
    if (p8) return int'((s + idx) & 64'h7FFFF);
    return int'((s + 2 * idx) & 64'h7FFFE);
  endfunction

  function automatic int memf(int a);
    return ((a * 40503) ^ (a >> 3) ^ 16'h2C5A) & 16'hFFFF;
  endfunction

  function automatic int expand(int v, bit p8);
    int b;
    if (p8) begin
      b = v & 255;
      if (b >= 128) b -= 256;
      return b * 256;
    end
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic tick();
    longint np, lsb, leb, idx;
    int p, n, r;
    @(negedge clk);
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 20000);
      finish_run();
    end
    // compare outputs against the model
    chk(addr_valid == (m_phase == 1), m_done ? "R12" : "R11", "addr_valid", addr_valid, m_phase == 1);
    chk(smp_ready == (m_phase == 2), "R11", "smp_ready", smp_ready, m_phase == 2);
    chk(out_valid == (m_phase == 3), "R11", "out_valid", out_valid, m_phase == 3);
    chk(ls_reached == m_ls, "R8", "ls_reached", ls_reached, m_ls);
    chk(voice_stop == m_stop, "R4", "voice_stop", voice_stop, m_stop);
    if (m_phase == 1) begin
      idx = m_pos >>> 12;
      r = mapaddr(m_start, idx, m_pcm);
      chk(rd_addr_cur == r, m_first ? "R1" : "R3", "rd_addr_cur", rd_addr_cur, r);
      r = mapaddr(m_start, idx + 1, m_pcm);
      chk(rd_addr_nxt == r, "R2", "rd_addr_nxt", rd_addr_nxt, r);
      chk(pos_frac == (m_pos & 12'hFFF), scen_tag, "pos_frac", pos_frac, m_pos & 12'hFFF);
      chk(dir_back == m_dir, scen_tag, "dir_back", dir_back, m_dir);
    end
    if (m_phase == 3)
      chk(out_sample == m_out, (sb_ctl != 0) ? "R10" : "R9", "out_sample", out_sample, m_out);
    // drive inputs for the coming edge
    key_on     = kon_req;
    addr_ready = stall ? (cyc % 3 != 0) : 1'b1;
    smp_valid  = stall ? (cyc % 4 != 1) : 1'b1;
    out_ready  = stall ? (cyc % 5 != 2) : 1'b1;
    smp_prev   = 16'(memf(m_iss_cur));
    smp_next   = 16'(memf(m_iss_nxt));
    // advance the model
    m_ls = 0; m_stop = 0;
    if (!rst_n) begin
      m_phase = 0;
    end else if (kon_req) begin
      m_pos = 0; m_dir = 0; m_seen = 0; m_stopping = 0; m_done = 0;
      m_start = int'(start_addr); m_pcm = pcm8; m_phase = 1; m_first = 1; m_outs = 0;
    end else begin
      case (m_phase)
        1: if (addr_ready) begin
          m_first = 0;
          m_iss_cur = mapaddr(m_start, m_pos >>> 12, m_pcm);
          m_iss_nxt = mapaddr(m_start, (m_pos >>> 12) + 1, m_pcm);
          m_frac = int'(m_pos & 12'hFFF);
          lsb = longint'(loop_start) * 4096;
          leb = longint'(loop_end) * 4096;
          np = m_dir ? m_pos - pitch_step : m_pos + pitch_step;
          if (!m_dir && np >= lsb && ls_link && !m_seen) begin m_ls = 1; m_seen = 1; end
          case (loop_mode)
            2'd0: if (np >= lsb && np >= leb) begin m_stop = 1; m_stopping = 1; end
            2'd1: if (np >= leb) np = np - (leb - lsb);
            2'd2: if (!m_dir && np >= lsb) begin np = leb - (np - lsb); m_dir = 1; end
                  else if (m_dir && np < lsb) np = leb - (lsb - np);
            default: if (!m_dir && np >= leb) begin np = 2 * leb - np; m_dir = 1; end
                     else if (m_dir && np < lsb) begin np = 2 * lsb - np; m_dir = 0; end
          endcase
          m_pos = np;
          m_phase = 2;
        end
        2: if (smp_valid) begin
          p = expand(memf(m_iss_cur), m_pcm);
          n = expand(memf(m_iss_nxt), m_pcm);
          r = (p + (((n - p) * m_frac) >>> 12)) & 16'hFFFF;
          if (sb_ctl[0]) r = r ^ 16'h7FFF;
          if (sb_ctl[1]) r = r ^ 16'h8000;
          m_out = r;
          m_phase = 3;
        end
        3: if (out_ready) begin
          m_outs++;
          if (m_stopping) begin m_phase = 0; m_done = 1; end
          else m_phase = 1;
        end
        default: ;
      endcase
    end
    kon_req = 0;
  endtask

  task automatic run_voice(int mode, bit p8, int st, int ls, int le, int step,
                           bit link, int sb, bit stl, int nout, string tag);
    loop_mode  = 2'(mode);
    pcm8       = p8;
    start_addr = 19'(st);
    loop_start = 16'(ls);
    loop_end   = 16'(le);
    pitch_step = 20'(step);
    ls_link    = link;
    sb_ctl     = 2'(sb);
    stall      = stl;
    scen_tag   = tag;
    kon_req    = 1;
    tick();
    while (!(m_outs >= nout || m_phase == 0)) tick();
    for (int k = 0; k < 6; k++) tick();
  endtask

  initial begin
    // R1: reset state, no stream valid
    for (int k = 0; k < 4; k++) tick();
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    // R5, R8: forward loop, 16-bit, fraction carried across the wrap
    run_voice(1, 0, 'h100, 4, 10, 'h1800, 1, 0, 0, 30, "R5");
    // R4, R12: one-shot, 8-bit, stops then stays idle
    run_voice(0, 1, 'h2000, 3, 8, 'h2400, 1, 0, 0, 40, "R4");
    // R6: reverse loop
    run_voice(2, 0, 'h40, 4, 10, 'h1100, 1, 0, 0, 40, "R6");
    // R7, R11: ping-pong with stalls on all three streams
    run_voice(3, 1, 'h3001, 2, 9, 'h0C00, 1, 0, 1, 40, "R7");
    // R10, R3: inversion controls, start near the top of memory
    run_voice(1, 0, 'h7FFF0, 1, 12, 'h0A40, 0, 1, 0, 15, "R3");
    run_voice(1, 1, 'h7FFFA, 1, 12, 'h0A40, 0, 2, 1, 15, "R10");
    run_voice(3, 0, 'h500, 0, 5, 'h1C80, 0, 3, 0, 20, "R7");
    // R8: link off, no pulse expected
    run_voice(1, 0, 'h10, 2, 6, 'h1000, 0, 0, 0, 12, "R8");
    // R1: key-on during play restarts at zero
    run_voice(3, 0, 'h80, 2, 7, 'h1300, 1, 0, 1, 5, "R1");
    run_voice(2, 1, 'h90, 3, 7, 'h0F00, 1, 0, 0, 25, "R6");
    finish_run();
  end
endmodule